// File: doc/BRIEF.md
# Long-Format Page Table Walker

This block walks a translation table hierarchy of up to four levels, in which every entry is a 64-bit descriptor. A request carries the virtual address, the level at which to start, the physical base of the first table, a granule select (4 KB or 64 KB) and the security state and privilege of the requester. The block fetches one descriptor per level over a simple held-request memory port. It classifies each descriptor as invalid, table, block or page, and it follows table entries to the next level until it reaches a leaf or a fault.

While walking, the block narrows a set of permission and security limits that table entries impose on all deeper levels. At the leaf it merges these limits with the leaf's own fields and returns the physical address, the permissions in a 3-bit form, the memory attributes and a fault code. If the leaf's access flag is clear, the block sets the flag, writes the updated descriptor back to the same address and marks the result dirty. The block handles one walk at a time. A caching structure in front of it issues requests on a miss.

Top module: `ptw_walker`

## Requirements
- R1: Descriptor bits [1:0] = 3 is a page at level 3 and a table at levels 0 to 2. Bits [1:0] = 0 or 2 is invalid and ends the walk with fault code 1 (translation) at that level. Fault code 0 means success and 2 means address size.
- R2: Bits [1:0] = 1 is a block at levels 1 and 2 with the 4 KB granule (invalid at levels 0 and 3), and a block only at level 2 with the 64 KB granule. Any other case ends the walk with fault 1.
- R3: The result address is the descriptor's address bits above the offset width, combined with the virtual address bits below it. The offset width is 12 for a 4 KB page, 16 for a 64 KB page, 30 for a level-1 block and 21 for a level-2 block with the 4 KB granule, and 29 for a 64 KB-granule block.
- R4: The descriptor address at level L is the table address (descriptor bits 47 down to the granule width g, or the request base at the start level) ORed with the index times 8. The index is g−3 bits of the virtual address starting at bit (g−3)·(3−L)+g, where g is 12 or 16.
- R5: Table bit 62 set forbids writes, and table bit 61 set forbids user access, at all deeper levels. The leaf is writable when its bit 7 is clear and user-accessible when its bit 6 is set. The 3-bit permission output has bit 2 = not writable, bit 1 = user and bit 0 = 0.
- R6: The execute-never output is leaf bit 54 ORed with any table bit 60 on the path. The privileged execute-never output is leaf bit 53 ORed with any table bit 59 on the path.
- R7: The secure output is set only when the requester is secure, no table on the path had bit 63 set, and leaf bit 5 is clear.
- R8: The global output is 1 for a high-privilege walk. Otherwise it is 0 for a secure requester whose walk turned non-secure. In all other cases it is the inverse of leaf bit 11.
- R9: A leaf with bit 10 clear is written back to its own address with bit 10 set, and the dirty output is 1. A leaf with bit 10 set causes no write, and the dirty output is 0.
- R10: A table or leaf output address with any bit set at or above the requested physical-address width ends the walk with fault 2 at that level.
- R11: The attribute index output is leaf bits [4:2], the shareability output is bits [9:8] and the contiguous output is bit 52.
- R12: A request is accepted only while ready is high. Ready stays low until the response. The response valid is a single-cycle pulse, and a memory request stays asserted with a stable address and kind until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | VA_W | Virtual address |
| req_level_i | input | 2 | Starting lookup level |
| req_base_i | input | OA_W | Physical base of the first table |
| req_gran64_i | input | 1 | 1 selects the 64 KB granule, 0 the 4 KB granule |
| req_secure_i | input | 1 | Requester is in secure state |
| req_high_el_i | input | 1 | Walk is for one of the two highest privilege levels |
| req_pa_bits_i | input | 6 | Physical-address width limit |
| mem_req_o | output | 1 | Memory access request, held until ack |
| mem_we_o | output | 1 | 1 for a descriptor write-back |
| mem_addr_o | output | OA_W | Descriptor address |
| mem_wdata_o | output | 64 | Write-back data |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_rdata_i | input | 64 | Descriptor read data |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_fault_o | output | 2 | 0 none, 1 translation, 2 address size |
| rsp_level_o | output | 2 | Level at which the walk ended |
| rsp_pa_o | output | OA_W | Physical address |
| rsp_ap_o | output | 3 | Permissions: bit 2 = not writable, bit 1 = user |
| rsp_xn_o | output | 1 | Execute never |
| rsp_pxn_o | output | 1 | Privileged execute never |
| rsp_global_o | output | 1 | Translation is global |
| rsp_secure_o | output | 1 | Targets secure memory |
| rsp_attr_idx_o | output | 3 | Attribute index |
| rsp_sh_o | output | 2 | Shareability |
| rsp_contig_o | output | 1 | Contiguous hint |
| rsp_dirty_o | output | 1 | Access flag was set and written back |

## Verification
Assertions check the following on every cycle:
- the response pulse is a single cycle;
- a memory request is held with a stable address until it is acknowledged;
- every write-back carries a set access flag;
- a successful address stays within the requested width;
- write, user and security limits never relax in the middle of a walk;
- high-privilege walks come back global, and non-secure requesters never get a secure result.

The per-level and per-granule type decode, the exact index and offset placement, and the combination of table limits with leaf fields need known table contents. The bench scenarios show these behaviours through sweeps over levels, type codes and every table and leaf permission pattern.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    DT_INVALID = 2'd0,
    DT_TABLE   = 2'd1,
    DT_BLOCK   = 2'd2,
    DT_PAGE    = 2'd3
  } desc_type_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLAT  = 2'd1,
    FLT_ASIZE = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EVAL, S_WB, S_RESP
  } walk_state_e;

  localparam int unsigned DESC_W = 64;
endpackage

// File: rtl/ptw_decode.sv
module ptw_decode
  import ptw_pkg::*;
#(
  parameter int unsigned OA_W = 48
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic [1:0]        level_i,
  input  logic              gran64_i,
  output desc_type_e        dtype_o,
  output logic [5:0]        off_bits_o,
  output logic [OA_W-1:0]   out_addr_o
);
  logic [5:0] gran_w;
  assign gran_w = gran64_i ? 6'd16 : 6'd12;

  always_comb begin
    unique case (desc_i[1:0])
      2'b11: dtype_o = (level_i == 2'd3) ? DT_PAGE : DT_TABLE;
      2'b01: begin
        if (gran64_i) dtype_o = (level_i == 2'd2) ? DT_BLOCK : DT_INVALID;
        else          dtype_o = (level_i == 2'd0 || level_i == 2'd3) ? DT_INVALID : DT_BLOCK;
      end
      default: dtype_o = DT_INVALID;
    endcase
  end

  always_comb begin
    if (dtype_o == DT_BLOCK) begin
      if (gran64_i)              off_bits_o = 6'd29;
      else if (level_i == 2'd1)  off_bits_o = 6'd30;
      else                       off_bits_o = 6'd21;
    end else begin
      off_bits_o = gran_w;  // page offset and table alignment
    end
  end

  assign out_addr_o = desc_i[OA_W-1:0] & ({OA_W{1'b1}} << off_bits_o);
endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int unsigned VA_W = 48
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      level_i,
  input  logic            gran64_i,
  output logic [15:0]     byte_off_o
);
  localparam int unsigned IDX_W = 13;

  logic [5:0]      lvl_rev;
  logic [5:0]      lo_bit;
  logic [VA_W-1:0] va_sh;
  logic [IDX_W-1:0] idx_mask;
  logic [IDX_W-1:0] idx;

  assign lvl_rev  = 6'(2'd3 - level_i);
  // stride = granule width - 3; low index bit = stride*(3-level) + granule width
  assign lo_bit   = gran64_i ? (6'd13 * lvl_rev + 6'd16) : (6'd9 * lvl_rev + 6'd12);
  assign va_sh    = va_i >> lo_bit;
  assign idx_mask = gran64_i ? 13'h1fff : 13'h01ff;
  assign idx      = va_sh[IDX_W-1:0] & idx_mask;
  assign byte_off_o = {idx, 3'b000};
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       init_secure_i,
  input  logic       upd_i,
  input  logic [4:0] tbl_attr_i,   // descriptor bits 63:59
  output logic       sec_lkp_o,
  output logic       rw_lim_o,
  output logic       usr_lim_o,
  output logic       xn_lim_o,
  output logic       pxn_lim_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_lkp_o <= 1'b0;
      rw_lim_o  <= 1'b1;
      usr_lim_o <= 1'b1;
      xn_lim_o  <= 1'b0;
      pxn_lim_o <= 1'b0;
    end else if (init_i) begin
      sec_lkp_o <= init_secure_i;
      rw_lim_o  <= 1'b1;
      usr_lim_o <= 1'b1;
      xn_lim_o  <= 1'b0;
      pxn_lim_o <= 1'b0;
    end else if (upd_i) begin
      if (tbl_attr_i[4]) sec_lkp_o <= 1'b0;
      if (tbl_attr_i[3]) rw_lim_o  <= 1'b0;
      if (tbl_attr_i[2]) usr_lim_o <= 1'b0;
      if (tbl_attr_i[1]) xn_lim_o  <= 1'b1;
      if (tbl_attr_i[0]) pxn_lim_o <= 1'b1;
    end
  end

  a_r5_rw_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !rw_lim_o) |=> !rw_lim_o);
  a_r5_usr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !usr_lim_o) |=> !usr_lim_o);
  a_r7_ns_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !sec_lkp_o) |=> !sec_lkp_o);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W = 48,
  parameter int unsigned OA_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_level_i,
  input  logic [OA_W-1:0]   req_base_i,
  input  logic              req_gran64_i,
  input  logic              req_secure_i,
  input  logic              req_high_el_i,
  input  logic [5:0]        req_pa_bits_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [OA_W-1:0]   mem_addr_o,
  output logic [DESC_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_fault_o,
  output logic [1:0]        rsp_level_o,
  output logic [OA_W-1:0]   rsp_pa_o,
  output logic [2:0]        rsp_ap_o,
  output logic              rsp_xn_o,
  output logic              rsp_pxn_o,
  output logic              rsp_global_o,
  output logic              rsp_secure_o,
  output logic [2:0]        rsp_attr_idx_o,
  output logic [1:0]        rsp_sh_o,
  output logic              rsp_contig_o,
  output logic              rsp_dirty_o
);
  localparam int unsigned AF_BIT = 10;

  walk_state_e       state_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        lvl_q;
  logic              g64_q, sec_q, hi_q;
  logic [5:0]        pab_q;
  logic [OA_W-1:0]   addr_q;
  logic [DESC_W-1:0] desc_q;

  logic              accept;
  desc_type_e        dtype;
  logic [5:0]        off_bits;
  logic [OA_W-1:0]   dec_addr;
  logic [VA_W-1:0]   ix_va;
  logic [1:0]        ix_lvl;
  logic              ix_g64;
  logic [15:0]       byte_off;
  logic              size_fault;
  logic              tbl_step;
  logic              sec_lkp, rw_lim, usr_lim, xn_lim, pxn_lim;
  logic [OA_W-1:0]   va_oa;
  logic              leaf_rw, leaf_usr;

  assign accept      = (state_q == S_IDLE) && req_valid_i;
  assign req_ready_o = (state_q == S_IDLE);

  ptw_decode #(.OA_W(OA_W)) u_decode (
    .desc_i     (desc_q),
    .level_i    (lvl_q),
    .gran64_i   (g64_q),
    .dtype_o    (dtype),
    .off_bits_o (off_bits),
    .out_addr_o (dec_addr)
  );

  // one index unit: start level from the request, next level during evaluation
  assign ix_va  = (state_q == S_IDLE) ? req_va_i     : va_q;
  assign ix_lvl = (state_q == S_IDLE) ? req_level_i  : lvl_q + 2'd1;
  assign ix_g64 = (state_q == S_IDLE) ? req_gran64_i : g64_q;

  ptw_index #(.VA_W(VA_W)) u_index (
    .va_i       (ix_va),
    .level_i    (ix_lvl),
    .gran64_i   (ix_g64),
    .byte_off_o (byte_off)
  );

  assign size_fault = |(dec_addr >> pab_q);
  assign tbl_step   = (state_q == S_EVAL) && (dtype == DT_TABLE) && !size_fault;

  ptw_perm u_perm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .init_i        (accept),
    .init_secure_i (req_secure_i),
    .upd_i         (tbl_step),
    .tbl_attr_i    (desc_q[63:59]),
    .sec_lkp_o     (sec_lkp),
    .rw_lim_o      (rw_lim),
    .usr_lim_o     (usr_lim),
    .xn_lim_o      (xn_lim),
    .pxn_lim_o     (pxn_lim)
  );

  assign va_oa    = OA_W'(va_q);
  assign leaf_rw  = ~desc_q[7] & rw_lim;
  assign leaf_usr = desc_q[6] & usr_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= S_IDLE;
      va_q           <= '0;
      lvl_q          <= '0;
      g64_q          <= 1'b0;
      sec_q          <= 1'b0;
      hi_q           <= 1'b0;
      pab_q          <= '0;
      addr_q         <= '0;
      desc_q         <= '0;
      rsp_fault_o    <= FLT_NONE;
      rsp_level_o    <= '0;
      rsp_pa_o       <= '0;
      rsp_ap_o       <= '0;
      rsp_xn_o       <= 1'b0;
      rsp_pxn_o      <= 1'b0;
      rsp_global_o   <= 1'b0;
      rsp_secure_o   <= 1'b0;
      rsp_attr_idx_o <= '0;
      rsp_sh_o       <= '0;
      rsp_contig_o   <= 1'b0;
      rsp_dirty_o    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q        <= req_va_i;
          lvl_q       <= req_level_i;
          g64_q       <= req_gran64_i;
          sec_q       <= req_secure_i;
          hi_q        <= req_high_el_i;
          pab_q       <= req_pa_bits_i;
          addr_q      <= req_base_i | OA_W'(byte_off);
          rsp_fault_o <= FLT_NONE;
          rsp_dirty_o <= 1'b0;
          state_q     <= S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          desc_q  <= mem_rdata_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          rsp_level_o <= lvl_q;
          if (dtype == DT_INVALID) begin
            rsp_fault_o <= FLT_XLAT;
            state_q     <= S_RESP;
          end else if (size_fault) begin
            rsp_fault_o <= FLT_ASIZE;
            state_q     <= S_RESP;
          end else if (dtype == DT_TABLE) begin
            addr_q  <= dec_addr | OA_W'(byte_off);
            lvl_q   <= lvl_q + 2'd1;
            state_q <= S_FETCH;
          end else begin
            rsp_pa_o       <= dec_addr | (va_oa & ~({OA_W{1'b1}} << off_bits));
            rsp_ap_o       <= {~leaf_rw, leaf_usr, 1'b0};
            rsp_xn_o       <= desc_q[54] | xn_lim;
            rsp_pxn_o      <= desc_q[53] | pxn_lim;
            rsp_contig_o   <= desc_q[52];
            rsp_sh_o       <= desc_q[9:8];
            rsp_attr_idx_o <= desc_q[4:2];
            rsp_secure_o   <= sec_lkp & ~desc_q[5];
            if (hi_q)                 rsp_global_o <= 1'b1;
            else if (sec_q & ~sec_lkp) rsp_global_o <= 1'b0;
            else                      rsp_global_o <= ~desc_q[11];
            if (!desc_q[AF_BIT]) begin
              desc_q[AF_BIT] <= 1'b1;
              rsp_dirty_o    <= 1'b1;
              state_q        <= S_WB;
            end else begin
              state_q <= S_RESP;
            end
          end
        end
        S_WB:   if (mem_ack_i) state_q <= S_RESP;
        S_RESP: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == S_FETCH) || (state_q == S_WB);
  assign mem_we_o    = (state_q == S_WB);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = desc_q;
  assign rsp_valid_o = (state_q == S_RESP);

  a_r12_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r12_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o));
  a_r9_wb_sets_af: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[AF_BIT] && rsp_dirty_o));
  a_r10_pa_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE) |-> ((rsp_pa_o >> pab_q) == '0));
  a_r8_high_el_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE && hi_q) |-> rsp_global_o);
  a_r7_ns_req_not_secure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE && !sec_q) |-> !rsp_secure_o);
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [1:0]  req_level = '0;
  logic [47:0] req_base = '0;
  logic        req_g64 = 1'b0, req_sec = 1'b0, req_hi = 1'b0;
  logic [5:0]  req_pab = 6'd48;
  logic        mem_req, mem_we, mem_ack;
  logic [47:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_xn, rsp_pxn, rsp_glb, rsp_sec, rsp_ctg, rsp_dirty;
  logic [1:0]  rsp_fault, rsp_level, rsp_sh;
  logic [47:0] rsp_pa;
  logic [2:0]  rsp_ap, rsp_attr;

  ptw_walker u_ptw_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_level_i(req_level), .req_base_i(req_base), .req_gran64_i(req_g64),
    .req_secure_i(req_sec), .req_high_el_i(req_hi), .req_pa_bits_i(req_pab),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_level_o(rsp_level),
    .rsp_pa_o(rsp_pa), .rsp_ap_o(rsp_ap), .rsp_xn_o(rsp_xn), .rsp_pxn_o(rsp_pxn),
    .rsp_global_o(rsp_glb), .rsp_secure_o(rsp_sec), .rsp_attr_idx_o(rsp_attr),
    .rsp_sh_o(rsp_sh), .rsp_contig_o(rsp_ctg), .rsp_dirty_o(rsp_dirty)
  );

  // memory model: one-cycle acknowledge
  logic [63:0] mem [logic [47:0]];
  logic [47:0] last_rd = '0;
  int          wr_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt = wr_cnt + 1;
        end else begin
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
          last_rd   <= mem_addr;
        end
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  logic [1:0]  r_fault, r_level, r_sh;
  logic [47:0] r_pa;
  logic [2:0]  r_ap, r_attr;
  logic        r_xn, r_pxn, r_glb, r_sec, r_ctg, r_dirty;

  localparam logic [47:0] T0 = 48'h10_0000, T1 = 48'h20_1000,
                          T2 = 48'h30_2000, T3 = 48'h40_3000;
  logic [47:0] leaf_a;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [47:0] ix(input logic [47:0] va, input int lvl, input bit g);
    int gw, s, lo;
    logic [63:0] v;
    gw = g ? 16 : 12;
    s  = gw - 3;
    lo = s * (3 - lvl) + gw;
    v  = {16'h0, va} >> lo;
    v  = v & ((64'd1 << s) - 1);
    return 48'(v << 3);
  endfunction

  task automatic do_walk(input logic [47:0] va, input logic [1:0] lvl, input logic [47:0] base,
                         input bit g, input bit sec, input bit hi, input logic [5:0] pab);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_level = lvl; req_base = base;
    req_g64 = g; req_sec = sec; req_hi = hi; req_pab = pab;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy ready", {63'h0, req_ready}, 64'h0);
    t = 0;
    while (rsp_valid !== 1'b1 && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 1000) chk("R12 response timeout", 64'h0, 64'h1);
    r_fault = rsp_fault; r_level = rsp_level; r_pa = rsp_pa; r_ap = rsp_ap;
    r_xn = rsp_xn; r_pxn = rsp_pxn; r_glb = rsp_glb; r_sec = rsp_sec;
    r_attr = rsp_attr; r_sh = rsp_sh; r_ctg = rsp_ctg; r_dirty = rsp_dirty;
    @(negedge clk);
    chk("R12 pulse", {63'h0, rsp_valid}, 64'h0);
  endtask

  task automatic build4k(input logic [47:0] va, input logic [63:0] t0b,
                         input logic [63:0] t1b, input logic [63:0] leaf);
    mem.delete();
    mem[T0 | ix(va, 0, 0)] = t0b | {16'h0, T1} | 64'h3;
    mem[T1 | ix(va, 1, 0)] = t1b | {16'h0, T2} | 64'h3;
    mem[T2 | ix(va, 2, 0)] = {16'h0, T3} | 64'h3;
    leaf_a = T3 | ix(va, 3, 0);
    mem[leaf_a] = leaf;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset ready", {63'h0, req_ready}, 64'h1);
    chk("R12 reset rsp", {63'h0, rsp_valid}, 64'h0);
    chk("R12 reset mem", {63'h0, mem_req}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // type decode, offsets and start-level indexing across levels, codes and granules
    for (int g = 0; g < 2; g++) begin
      for (int l = 0; l < 4; l++) begin
        for (int c = 0; c < 4; c++) begin
          automatic logic [47:0] va   = 48'hA5C3_9E71_2468;
          automatic logic [47:0] base = 48'h0000_0010_0000;
          automatic logic [47:0] oa   = 48'h8765_4327_3000;
          automatic logic [47:0] da   = base | ix(va, l, g);
          automatic int kind; // 0 inv 1 table 2 block 3 page
          automatic int n;
          automatic logic [47:0] m, nx;
          mem.delete();
          mem[da] = {16'h0, oa} | 64'h400 | 64'(c);
          do_walk(va, 2'(l), base, g[0], 1'b0, 1'b0, 6'd48);
          if (c == 3)      kind = (l == 3) ? 3 : 1;
          else if (c == 1) kind = g ? ((l == 2) ? 2 : 0) : ((l == 1 || l == 2) ? 2 : 0);
          else             kind = 0;
          if (kind == 0) begin
            chk(c == 1 ? "R2 block invalid fault" : "R1 invalid fault", 64'(r_fault), 64'd1);
            chk("R1 fault level", 64'(r_level), 64'(l));
            chk("R4 start address", 64'(last_rd), 64'(da));
          end else if (kind == 1) begin
            m  = (48'd1 << (g ? 16 : 12)) - 1;
            nx = (oa & ~m) | ix(va, l + 1, g[0]);
            chk("R4 next address", 64'(last_rd), 64'(nx));
            chk("R1 table then empty", 64'(r_fault), 64'd1);
            chk("R1 table level step", 64'(r_level), 64'(l + 1));
          end else begin
            if (kind == 3) n = g ? 16 : 12;
            else           n = g ? 29 : ((l == 1) ? 30 : 21);
            m = (48'd1 << n) - 1;
            chk(kind == 2 ? "R2 block ok" : "R1 page ok", 64'(r_fault), 64'd0);
            chk("R3 leaf pa", 64'(r_pa), 64'((oa & ~m) | (va & m)));
            chk("R3 leaf level", 64'(r_level), 64'(l));
          end
        end
      end
    end

    // hierarchical permission sweep over table and leaf bits
    for (int p = 0; p < 16; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int x = 0; x < 4; x++) begin
          automatic logic [47:0] va = 48'h1357_9BDF_0ABC;
          automatic logic [63:0] t0b = (p[1] ? 64'd1 << 62 : 64'd0) | (p[2] ? 64'd1 << 60 : 64'd0);
          automatic logic [63:0] t1b = (p[0] ? 64'd1 << 61 : 64'd0) | (p[3] ? 64'd1 << 59 : 64'd0);
          automatic logic [63:0] lf  = 64'h0000_1234_5000 | (64'(a) << 6) |
                                       (x[0] ? 64'd1 << 54 : 64'd0) | (x[1] ? 64'd1 << 53 : 64'd0) |
                                       64'h403;
          automatic bit rw  = !a[1] && !p[1];
          automatic bit usr = a[0] && !p[0];
          build4k(va, t0b, t1b, lf);
          do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd48);
          chk("R5 ap", 64'(r_ap), 64'({!rw, usr, 1'b0}));
          chk("R6 xn", 64'(r_xn), 64'(x[0] | p[2]));
          chk("R6 pxn", 64'(r_pxn), 64'(x[1] | p[3]));
          if (p == 0 && a == 0 && x == 0)
            chk("R4 four-level pa", 64'(r_pa), 64'(48'h1234_5000 | (va & 48'hFFF)));
        end
      end
    end

    // 64 KB granule chain from level 1
    begin
      automatic logic [47:0] va = 48'hC000_0123_4567;
      automatic logic [47:0] oa = 48'h0000_ABCD_0000;
      mem.delete();
      mem[T0 | ix(va, 1, 1)]           = 64'h21_0000 | 64'h3;
      mem[48'h21_0000 | ix(va, 2, 1)]  = 64'h32_0000 | 64'h3;
      mem[48'h32_0000 | ix(va, 3, 1)]  = {16'h0, oa} | 64'h403;
      do_walk(va, 2'd1, T0, 1'b1, 1'b0, 1'b0, 6'd48);
      chk("R4 64k chain fault", 64'(r_fault), 64'd0);
      chk("R3 64k page pa", 64'(r_pa), 64'(oa | (va & 48'hFFFF)));
    end

    // security and global rules
    begin
      automatic logic [47:0] va = 48'h0246_8ACE_1357;
      automatic logic [63:0] base_lf = 64'h0000_5555_6000 | 64'h403;
      build4k(va, 0, 0, base_lf);
      do_walk(va, 2'd0, T0, 1'b0, 1'b1, 1'b0, 6'd48);
      chk("R7 secure leaf", 64'(r_sec), 64'd1);
      chk("R8 secure global", 64'(r_glb), 64'd1);
      build4k(va, 0, 0, base_lf | 64'h20);
      do_walk(va, 2'd0, T0, 1'b0, 1'b1, 1'b0, 6'd48);
      chk("R7 ns leaf bit", 64'(r_sec), 64'd0);
      chk("R8 still secure lookup global", 64'(r_glb), 64'd1);
      build4k(va, 0, 64'd1 << 63, base_lf);
      do_walk(va, 2'd0, T0, 1'b0, 1'b1, 1'b0, 6'd48);
      chk("R7 ns table", 64'(r_sec), 64'd0);
      chk("R8 turned ns not global", 64'(r_glb), 64'd0);
      do_walk(va, 2'd0, T0, 1'b0, 1'b1, 1'b1, 6'd48);
      chk("R8 high level global", 64'(r_glb), 64'd1);
      build4k(va, 0, 0, base_lf | 64'h800);
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd48);
      chk("R8 ng leaf", 64'(r_glb), 64'd0);
      chk("R7 ns requester", 64'(r_sec), 64'd0);
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b1, 6'd48);
      chk("R8 high level overrides ng", 64'(r_glb), 64'd1);
    end

    // access flag write-back
    begin
      automatic logic [47:0] va = 48'h0000_0FED_C000;
      automatic logic [63:0] lf = 64'h0000_7777_8000 | 64'h3;
      automatic int w0;
      build4k(va, 0, 0, lf);
      w0 = wr_cnt;
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd48);
      chk("R9 dirty set", 64'(r_dirty), 64'd1);
      chk("R9 one write", 64'(wr_cnt - w0), 64'd1);
      chk("R9 written value", mem[leaf_a], lf | 64'h400);
      w0 = wr_cnt;
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd48);
      chk("R9 no dirty when set", 64'(r_dirty), 64'd0);
      chk("R9 no write when set", 64'(wr_cnt - w0), 64'd0);
      chk("R9 memory unchanged", mem[leaf_a], lf | 64'h400);
    end

    // address-size fault
    begin
      automatic logic [47:0] va = 48'h0000_1111_2345;
      build4k(va, 0, 0, 64'h0000_1000_0000_5000 | 64'h403);
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd40);
      chk("R10 leaf size fault", 64'(r_fault), 64'd2);
      chk("R10 leaf fault level", 64'(r_level), 64'd3);
      build4k(va, 0, 0, 64'h0000_0012_3456_7000 | 64'h403);
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd40);
      chk("R10 in range ok", 64'(r_fault), 64'd0);
      mem[T0 | ix(va, 0, 0)] = 64'h0000_2000_0000_0000 | 64'h3;
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd40);
      chk("R10 table size fault", 64'(r_fault), 64'd2);
      chk("R10 table fault level", 64'(r_level), 64'd0);
    end

    // attribute fields
    begin
      automatic logic [47:0] va = 48'h0000_2222_3333;
      build4k(va, 0, 0, 64'h0010_0000_0999_0000 | 64'h200 | 64'h14 | 64'h403);
      do_walk(va, 2'd0, T0, 1'b0, 1'b0, 1'b0, 6'd48);
      chk("R11 attr index", 64'(r_attr), 64'd5);
      chk("R11 shareability", 64'(r_sh), 64'd2);
      chk("R11 contiguous", 64'(r_ctg), 64'd1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule